// File: doc/BRIEF.md
# Cluster-Segment Address Translator

This block sits on the path from one initiator to the local interconnect. It turns 40-bit machine addresses into 40-bit physical addresses, so that a virtual machine reaches only its own rectangle of clusters and the device segments it was granted. Translation depends on topology. The top 8 bits of the physical address name the destination cluster, with X in the upper nibble and Y in the lower one. The leading bits of the 32-bit machine address pick a cluster inside the virtual machine's rectangle, and the block adds that position to the rectangle's origin. A small table of base/mask pairs marks device segments. A request that falls in a valid segment leaves with its address unchanged and a device flag set.

The block has two states. After reset it is disabled: every address passes through unchanged, and software fills in the geometry and the device table through a simple write port. An activate command locks the registers and turns translation on. Only a deactivate command unlocks them again. Requests move through one translation register and a short output FIFO under valid/ready handshakes, in order and without loss.

Top module: `seg_addr_xlat`

## Requirements
- R1: After reset the block is disabled, `outValid` is 0 and `inReady` is 1.
- R2: While disabled, each request leaves with `outAddr` equal to `inAddr` and `outExt` equal to 0, whatever the geometry or the device table holds.
- R3: Configuration writes take effect in one cycle, and only while disabled. While enabled they are ignored. `cmdActivate` moves disabled to enabled, and `cmdDeactivate` moves enabled back to disabled.
- R4: When enabled and no device entry matches, `vx` is the top MX bits of `inAddr[31:0]`, and `vy` is the next MY bits below them. `outAddr[39:36]` is (originX+vx) mod 16, `outAddr[35:32]` is (originY+vy) mod 16, `outAddr[31:0]` equals `inAddr[31:0]`, and `outExt` is 0. An MX or MY of 0 gives a coordinate of 0.
- R5: With origin (0,2) and MX=MY=1, machine address 0x41487424 becomes physical address 0x0341487424.
- R6: When enabled, an access for which (`inAddr` AND mask) equals base for at least one entry whose valid bit is set leaves unchanged with `outExt`=1. Entries whose valid bit is clear never match.
- R7: A request accepted at a clock edge appears on the output after the second following edge. With `outReady` held at 1, back-to-back requests leave one per cycle.
- R8: Under output backpressure, `outAddr` and `outExt` hold steady while `outValid` is 1 and `outReady` is 0. No request is dropped, duplicated or reordered.
- R9: Register selects for `cfgSel`: 0 is geometry (data[3:0] originX, [7:4] originY, [10:8] MX, [14:12] MY); 1 is the entry valid bits (data[i] for entry i); 2+2i is the base of entry i; 3+2i is the mask of entry i, which holds the two's complement of the segment size. There are entries 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 4 | Configuration register select |
| cfgWrData | input | 40 | Configuration write data |
| cmdActivate | input | 1 | Lock the configuration and enable translation |
| cmdDeactivate | input | 1 | Return to the disabled state |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request accepted this cycle when high with inValid |
| inAddr | input | 40 | Machine address |
| outValid | output | 1 | Translated request valid |
| outReady | input | 1 | Downstream can take the request |
| outAddr | output | 40 | Physical address |
| outExt | output | 1 | 1 when the request targets a granted device segment |

## Verification
The bench builds the block with its default values: a 2-entry output FIFO and 5 device entries. This keeps the state space small enough to walk every VM-relative cluster for every MX and MY from 0 to 2, with origins chosen so that the coordinate sums wrap past 15. It also makes room to probe every device entry at its last in-segment word and at the first word past the segment, including an entry left invalid. The shallow FIFO fills within two stalled cycles, so an irregular `outReady` pattern exercises full, empty and simultaneous push-and-pop states, and the exact two-edge latency can be counted directly.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int ADDR_W  = 40;
  localparam int LOW_W   = 32;
  localparam int COORD_W = 4;
  localparam int MBITS_W = 3;
  localparam int DEV_N   = 5;
  localparam int SEL_W   = 4;

  localparam logic [SEL_W-1:0] SEL_GEOM  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_VALID = SEL_W'(1);
  localparam int SEL_TABLE0 = 2;

  typedef struct packed {
    logic                              enabled;
    logic [COORD_W-1:0]                origX;
    logic [COORD_W-1:0]                origY;
    logic [MBITS_W-1:0]                mx;
    logic [MBITS_W-1:0]                my;
    logic [DEV_N-1:0]                  devValid;
    logic [DEV_N-1:0][ADDR_W-1:0]      devBase;
    logic [DEV_N-1:0][ADDR_W-1:0]      devMask;
  } xlat_cfg_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import seg_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              cmdActivate,
  input  logic              cmdDeactivate,
  output xlat_cfg_t         cfg
);
  logic                         enabledQ;
  logic [COORD_W-1:0]           origXQ, origYQ;
  logic [MBITS_W-1:0]           mxQ, myQ;
  logic [DEV_N-1:0]             validQ;
  logic [DEV_N-1:0][ADDR_W-1:0] baseQ, maskQ;
  logic                         wrOk;

  assign wrOk = cfgWrEn && !enabledQ;

  // lifecycle: disabled (writable) <-> enabled (locked)
  always_ff @(posedge clk) begin
    if (!rstN)                              enabledQ <= 1'b0;
    else if (!enabledQ && cmdActivate)      enabledQ <= 1'b1;
    else if (enabledQ && cmdDeactivate)     enabledQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      origXQ <= '0; origYQ <= '0; mxQ <= '0; myQ <= '0;
      validQ <= '0; baseQ <= '0; maskQ <= '0;
    end else if (wrOk) begin
      if (cfgSel == SEL_GEOM) begin
        origXQ <= cfgWrData[COORD_W-1:0];
        origYQ <= cfgWrData[2*COORD_W-1:COORD_W];
        mxQ    <= cfgWrData[8 +: MBITS_W];
        myQ    <= cfgWrData[12 +: MBITS_W];
      end
      if (cfgSel == SEL_VALID) validQ <= cfgWrData[DEV_N-1:0];
      for (int i = 0; i < DEV_N; i++) begin
        if (cfgSel == SEL_W'(SEL_TABLE0 + 2*i))     baseQ[i] <= cfgWrData;
        if (cfgSel == SEL_W'(SEL_TABLE0 + 2*i + 1)) maskQ[i] <= cfgWrData;
      end
    end
  end

  always_comb begin
    cfg.enabled  = enabledQ;
    cfg.origX    = origXQ;
    cfg.origY    = origYQ;
    cfg.mx       = mxQ;
    cfg.my       = myQ;
    cfg.devValid = validQ;
    cfg.devBase  = baseQ;
    cfg.devMask  = maskQ;
  end

  p_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    enabledQ && cfgWrEn |=> $stable({origXQ, origYQ, mxQ, myQ, validQ, baseQ, maskQ}));
  p_activate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enabledQ && cmdActivate |=> enabledQ);
  p_deactivate_r3: assert property (@(posedge clk) disable iff (!rstN)
    enabledQ && cmdDeactivate |=> !enabledQ);
endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import seg_xlat_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlat_cfg_t         cfg,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outExt
);
  localparam int ENTRY_W = ADDR_W + 1;
  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

  // translation stage
  logic              s1Valid;
  logic [ADDR_W-1:0] s1Addr;
  logic [DEV_N-1:0]  hit;
  logic              isExt;
  logic [5:0]        shX, shY;
  logic [COORD_W-1:0] vmX, vmY, physX, physY;
  logic [ADDR_W-1:0] xlatAddr;

  generate
    for (genvar i = 0; i < DEV_N; i++) begin : g_match
      assign hit[i] = cfg.devValid[i] &&
                      ((s1Addr & cfg.devMask[i]) == cfg.devBase[i]);
    end
  endgenerate

  assign isExt = cfg.enabled && (|hit);
  assign shX   = 6'(LOW_W) - 6'(cfg.mx);
  assign shY   = 6'(LOW_W) - 6'(cfg.mx) - 6'(cfg.my);
  assign vmX   = COORD_W'(64'(s1Addr[LOW_W-1:0]) >> shX);
  assign vmY   = COORD_W'((64'(s1Addr[LOW_W-1:0]) >> shY) &
                          ((64'd1 << cfg.my) - 64'd1));
  assign physX = cfg.origX + vmX;
  assign physY = cfg.origY + vmY;

  always_comb begin
    if (!cfg.enabled || isExt) xlatAddr = s1Addr;
    else                       xlatAddr = {physX, physY, s1Addr[LOW_W-1:0]};
  end

  // output FIFO
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               push, pop, room;

  assign outValid = (count != '0);
  assign pop      = outValid && outReady;
  assign room     = (count < CNT_W'(FIFO_DEPTH)) || pop;
  assign push     = s1Valid && room;
  assign inReady  = !s1Valid || push;
  assign {outExt, outAddr} = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Addr  <= '0;
    end else if (inValid && inReady) begin
      s1Valid <= 1'b1;
      s1Addr  <= inAddr;
    end else if (push) begin
      s1Valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {isExt, xlatAddr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  p_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> s1Valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outExt));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FIFO_DEPTH));
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid && !push |=> s1Valid && $stable(s1Addr));
endmodule

// File: rtl/seg_addr_xlat.sv
module seg_addr_xlat
  import seg_xlat_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              cmdActivate,
  input  logic              cmdDeactivate,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outExt
);
  xlat_cfg_t cfg;

  xlat_ctrl u_ctrl (
    .clk, .rstN, .cfgWrEn, .cfgSel, .cfgWrData,
    .cmdActivate, .cmdDeactivate, .cfg
  );

  xlat_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk, .rstN, .cfg, .inValid, .inReady, .inAddr,
    .outValid, .outReady, .outAddr, .outExt
  );
endmodule

// File: tb/seg_addr_xlat_tb.sv
`timescale 1ns/100ps
module seg_addr_xlat_tb;
  logic        clk = 0, rstN = 0;
  logic        cfgWrEn = 0, cmdActivate = 0, cmdDeactivate = 0;
  logic [3:0]  cfgSel = 0;
  logic [39:0] cfgWrData = 0, inAddr = 0;
  logic        inValid = 0, outReady = 1;
  logic        inReady, outValid, outExt;
  logic [39:0] outAddr;

  always #2 clk = ~clk;

  seg_addr_xlat u_dut (.*);

  int nTests = 0, nFail = 0, cyc = 0;
  bit reported = 0;
  always @(posedge clk) cyc++;

  // bench model of the configuration
  bit          mEn = 0;
  int          mOx = 0, mOy = 0, mMx = 0, mMy = 0;
  logic [4:0]  mValid = 0;
  logic [39:0] mBase [5];
  logic [39:0] mMask [5];

  // scoreboard
  logic [39:0] expAddr [512];
  bit          expExt  [512];
  string       expTag  [512];
  int          popCyc  [512];
  int          wrIdx = 0, rdIdx = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FIFAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  function automatic logic [40:0] model(input logic [39:0] a);
    longint lo, vx, vy;
    if (!mEn) return {1'b0, a};
    for (int i = 0; i < 5; i++)
      if (mValid[i] && ((a & mMask[i]) == mBase[i])) return {1'b1, a};
    lo = longint'(a[31:0]);
    vx = (lo >> (32 - mMx)) & ((64'd1 << mMx) - 1);
    vy = (lo >> (32 - mMx - mMy)) & ((64'd1 << mMy) - 1);
    return {1'b0, 4'((mOx + vx) % 16), 4'((mOy + vy) % 16), a[31:0]};
  endfunction

  function automatic logic [39:0] geom(input int ox, input int oy, input int mx, input int my);
    return 40'(ox | (oy << 4) | (mx << 8) | (my << 12));
  endfunction

  // R9 register map, model follows only while disabled (R3)
  task automatic wrCfg(input int sel, input logic [39:0] d);
    cfgWrEn = 1; cfgSel = 4'(sel); cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 0;
    if (!mEn) begin
      if (sel == 0) begin
        mOx = int'(d[3:0]); mOy = int'(d[7:4]); mMx = int'(d[10:8]); mMy = int'(d[14:12]);
      end else if (sel == 1) mValid = d[4:0];
      else if (sel % 2 == 0) mBase[(sel-2)/2] = d;
      else mMask[(sel-3)/2] = d;
    end
  endtask

  task automatic activate();
    cmdActivate = 1; @(posedge clk); #1; cmdActivate = 0; mEn = 1;
  endtask
  task automatic deactivate();
    cmdDeactivate = 1; @(posedge clk); #1; cmdDeactivate = 0; mEn = 0;
  endtask

  task automatic drain();
    wait (rdIdx == wrIdx);
    @(posedge clk); #1;
  endtask

  task automatic sendExp(input logic [39:0] a, input logic [40:0] e, input string tag);
    bit acc;
    expAddr[wrIdx] = e[39:0]; expExt[wrIdx] = e[40]; expTag[wrIdx] = tag; wrIdx++;
    inValid = 1; inAddr = a;
    do begin
      @(negedge clk); acc = inReady;
      @(posedge clk); #1;
    end while (!acc);
    inValid = 0;
  endtask

  task automatic send(input logic [39:0] a, input string tag);
    sendExp(a, model(a), tag);
  endtask

  // output monitor: order, values, stability under stall (R8)
  bit stallPrev = 0; logic [39:0] stallAddr; bit stallExt;
  always @(negedge clk) if (rstN) begin
    if (stallPrev)
      chk(outValid && outAddr == stallAddr && outExt == stallExt, "R8 hold",
          {23'b0, outExt, outAddr}, {23'b0, stallExt, stallAddr});
    stallPrev = outValid && !outReady;
    stallAddr = outAddr; stallExt = outExt;
    if (outValid && outReady) begin
      if (rdIdx >= wrIdx) chk(0, "R8 extra output", {23'b0, outExt, outAddr}, 0);
      else begin
        chk(outAddr == expAddr[rdIdx] && outExt == expExt[rdIdx], expTag[rdIdx],
            {23'b0, outExt, outAddr}, {23'b0, expExt[rdIdx], expAddr[rdIdx]});
        popCyc[rdIdx] = cyc;
        rdIdx++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 0);
    report();
  end

  initial begin
    int first;
    repeat (3) @(posedge clk); #1;
    rstN = 1;
    @(negedge clk);
    // R1
    chk(outValid == 0 && inReady == 1, "R1 reset state", {outValid, inReady}, 2'b01);
    @(posedge clk); #1;

    // R2: disabled passes through even with config loaded
    wrCfg(0, geom(3, 4, 1, 1));
    wrCfg(2, 40'h0040000000); wrCfg(3, 40'hFFFFFFF000); wrCfg(1, 40'h1);
    send(40'h0040000010, "R2 identity in device range");
    send(40'h00C0001234, "R2 identity internal");
    send(40'h0012345678, "R2 identity");
    drain();

    // R5 example
    wrCfg(1, 40'h0);
    wrCfg(0, geom(0, 2, 1, 1));
    activate();
    sendExp(40'h0041487424, {1'b0, 40'h0341487424}, "R5 example");
    drain(); deactivate();

    // R4 sweep: MX, MY in 0..2, all VM clusters, origins that wrap
    for (int mx = 0; mx <= 2; mx++)
      for (int my = 0; my <= 2; my++) begin
        int idx = mx * 3 + my;
        wrCfg(0, geom((3 * idx + 13) % 16, (5 * idx + 14) % 16, mx, my));
        activate();
        for (int vx = 0; vx < (1 << mx); vx++)
          for (int vy = 0; vy < (1 << my); vy++) begin
            longint a = (longint'(vx) << (32 - mx)) | (longint'(vy) << (32 - mx - my));
            a = a | (longint'(32'h0ABC_D5E4) & ((64'd1 << (32 - mx - my)) - 1));
            send(40'(a), "R4 remap");
          end
        drain(); deactivate();
      end

    // R6 device table, entry 3 left invalid (R9 selects)
    for (int i = 0; i < 5; i++) begin
      logic [39:0] sz = 40'h100 << i;
      wrCfg(2 + 2 * i, 40'h0090000000 + 40'(i) * 40'h100000);
      wrCfg(3 + 2 * i, ~(sz - 40'h1));
    end
    wrCfg(1, 40'b10111);
    wrCfg(0, geom(1, 1, 2, 2));
    activate();
    for (int i = 0; i < 5; i++) begin
      logic [39:0] b = 40'h0090000000 + 40'(i) * 40'h100000;
      logic [39:0] sz = 40'h100 << i;
      send(b, "R6 base");
      send(b + sz - 40'h4, "R6 last word");
      send(b + sz, "R6 past segment");
    end
    drain();

    // R3 lock: writes while enabled are ignored
    wrCfg(0, geom(9, 9, 1, 1));
    wrCfg(1, 40'h0);
    send(40'h0090000000, "R3 table locked");
    send(40'h0040000010, "R3 geometry locked");
    drain(); deactivate();
    send(40'h0040000010, "R3 deactivate to identity");
    drain();
    wrCfg(0, geom(9, 9, 1, 1));
    activate();
    send(40'h0040000010, "R3 rewrite after deactivate");
    drain();

    // R7 latency
    inValid = 1; inAddr = 40'h0000000100;
    expAddr[wrIdx] = model(inAddr)[39:0]; expExt[wrIdx] = 0; expTag[wrIdx] = "R7 latency data"; wrIdx++;
    @(negedge clk); chk(inReady, "R7 ready", {63'b0, inReady}, 1);
    @(posedge clk); #1; inValid = 0;
    @(negedge clk); chk(!outValid, "R7 not after one edge", {63'b0, outValid}, 0);
    @(negedge clk); chk(outValid, "R7 valid after two edges", {63'b0, outValid}, 1);
    drain();

    // R7 throughput
    first = wrIdx;
    for (int k = 0; k < 8; k++) send(40'h0000001000 + 40'(k), "R7 stream");
    drain();
    chk(popCyc[first + 7] - popCyc[first] == 7, "R7 one per cycle",
        popCyc[first + 7] - popCyc[first], 7);

    // R8 backpressure with irregular ready
    fork
      begin
        for (int k = 0; k < 60; k++) begin
          outReady = ((k % 5) == 1) || ((k % 3) == 0);
          @(posedge clk); #1;
        end
        outReady = 1;
      end
      for (int k = 0; k < 20; k++) send(40'h0080000000 + 40'(k * 4), "R8 order");
    join
    drain();
    chk(rdIdx == wrIdx, "R8 all delivered", rdIdx, wrIdx);
    repeat (4) @(posedge clk);
    report();
  end
endmodule